// File: doc/BRIEF.md
# Transmit Holding Byte Status and Interrupt Controller

This block sits between a CPU and a serial transmitter. It holds one outgoing byte, reports whether the holding slot is free, and raises a transmit interrupt-pending flag each time the slot goes from holding a byte to free. The slot goes free when the transmitter's shift register takes the byte. In synchronous operation the transmitter also reports when a frame ends: the last check-sum bit has left the shift register and an idle pattern has been loaded in its place. That event raises the pending flag, so the CPU can start the next frame.

The CPU can clear the pending flag in two ways: by writing the next byte, or by issuing a clear command. The flag reaches the interrupt line only when both the transmit enable and the master enable are set. The status bit keeps updating when interrupts are off, so software can poll it. The block also watches for a byte written while the two check-sum bytes are going out. Such a write cuts the frame short, and the block records it in a sticky overrun bit.

The block resets from three sources: the active-low hardware reset, a software-issued full reset, and a per-channel reset.

Top module: `txbuf_irq_ctrl`

## Requirements
- R1: The controller returns to its idle state one cycle after any of three resets: `rst_n` low, `soft_hw_rst` high, or `chan_rst` high. In the idle state `buf_empty`=1, `tx_ip`=0 and `crc_overrun`=0.
- R2: A cycle with `cpu_wr`=1 stores `cpu_data` in the holding slot, and `buf_empty` reads 0 from the next cycle. A write to a slot that already holds a byte replaces that byte.
- R3: `sr_load` is high exactly when `sr_ready`=1 and `buf_empty`=0, with `sr_data` showing the held byte. After such a load `buf_empty` reads 1 in the next cycle, unless `cpu_wr` was also high in the load cycle.
- R4: `tx_ip` is set only by a transition of the slot from holding a byte to free while `tx_ie`=1. Raising `tx_ie` while the slot is already free leaves `tx_ip` at 0.
- R5: With `tx_ie`=0, `buf_empty` still follows writes and loads, and `tx_ip` stays 0.
- R6: When `sync_mode`=1, a `crc_end` pulse with `tx_ie`=1 sets `tx_ip` in the next cycle while `buf_empty` reads 1. When `sync_mode`=0, `crc_end` is ignored.
- R7: `tx_ip` clears in the cycle after a `cpu_wr` or a `rst_txint_cmd`. If a set event (load or frame end) falls in the same cycle as `rst_txint_cmd`, the set event wins.
- R8: `tx_irq` is high only while `tx_ip`, `tx_ie` and `mie` are all 1. Clearing either enable masks the line but keeps `tx_ip`.
- R9: With `sync_mode`=1, a `cpu_wr` from the `crc_first_load` cycle up to, but not including, the `crc_end` cycle sets `crc_overrun` in the next cycle. The bit stays set until a reset.
- R10: A `cpu_wr` in the `crc_end` cycle, or outside the check-sum window, leaves `crc_overrun` at 0. `crc_first_load` is ignored when `sync_mode`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_hw_rst | input | 1 | Software-issued full reset, synchronous |
| chan_rst | input | 1 | Channel reset, synchronous |
| sync_mode | input | 1 | 1 when the channel runs a synchronous protocol |
| cpu_wr | input | 1 | CPU data write strobe |
| cpu_data | input | DATA_W | Byte written by the CPU |
| tx_ie | input | 1 | Transmit interrupt enable |
| mie | input | 1 | Master interrupt enable |
| rst_txint_cmd | input | 1 | Command pulse that clears the pending flag |
| sr_ready | input | 1 | Shift register can accept a byte |
| sr_load | output | 1 | Byte transferred to the shift register this cycle |
| sr_data | output | DATA_W | Held byte presented to the shift register |
| crc_first_load | input | 1 | First check-sum byte entered the shift register |
| crc_end | input | 1 | Last check-sum bit left; idle pattern loaded |
| buf_empty | output | 1 | Holding slot is free |
| tx_ip | output | 1 | Transmit interrupt pending |
| tx_irq | output | 1 | Gated transmit interrupt request |
| crc_overrun | output | 1 | Sticky: a frame was cut short by a late write |

## Verification
Two kinds of fault are the most likely: a pending flag set by the enable rather than by a drain event, and a check-sum window that is off by one cycle. Either fault appears at `tx_ip` or `crc_overrun` one clock after the event that causes it. A slot state that disagrees with the data shows up at once, as an `sr_load` pulse while `buf_empty` is high or as a load that never happens. An overrun bit that is not sticky is exposed by sampling it again several cycles after the window has closed.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;

  // Next value of the pending flag: a set event takes priority over a clear.
  function automatic logic ip_next(input logic cur, input logic set_evt, input logic clr_evt);
    if (set_evt)      return 1'b1;
    else if (clr_evt) return 1'b0;
    else              return cur;
  endfunction

  // A write counts as late from the first check-sum load up to, but not
  // including, the frame-end cycle.
  function automatic logic in_crc_window(input logic win_q, input logic first_evt, input logic end_evt);
    return (win_q | first_evt) & ~end_evt;
  endfunction

  // Next value of the slot-free bit.
  function automatic logic empty_next(input logic cur, input logic wr, input logic load);
    if (wr)        return 1'b0;
    else if (load) return 1'b1;
    else           return cur;
  endfunction

endpackage

// File: rtl/txbuf_hold.sv
module txbuf_hold
  import txbuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_clr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sr_ready,
  output logic              empty,
  output logic [DATA_W-1:0] data,
  output logic              load_evt,
  output logic              drain_evt
);

  logic              empty_q;
  logic [DATA_W-1:0] data_q;

  assign load_evt  = sr_ready & ~empty_q;
  assign drain_evt = load_evt & ~wr;
  assign empty     = empty_q;
  assign data      = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
    end else if (sync_clr) begin
      empty_q <= 1'b1;
    end else begin
      empty_q <= empty_next(empty_q, wr, load_evt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (wr) begin
      data_q <= wr_data;
    end
  end

endmodule

// File: rtl/txbuf_crc_guard.sv
module txbuf_crc_guard
  import txbuf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_clr,
  input  logic sync_mode,
  input  logic first_load,
  input  logic crc_end,
  input  logic wr,
  output logic frame_end_evt,
  output logic window_open,
  output logic overrun_hit,
  output logic overrun
);

  logic win_q;
  logic ovr_q;
  logic first_s;

  assign first_s       = first_load & sync_mode;
  assign frame_end_evt = crc_end & sync_mode;
  assign window_open   = in_crc_window(win_q, first_s, frame_end_evt);
  assign overrun_hit   = wr & window_open;
  assign overrun       = ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0;
    end else if (sync_clr || frame_end_evt) begin
      win_q <= 1'b0;
    end else if (first_s) begin
      win_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
    end else if (sync_clr) begin
      ovr_q <= 1'b0;
    end else if (overrun_hit) begin
      ovr_q <= 1'b1;
    end
  end

endmodule

// File: rtl/txbuf_irq_flag.sv
module txbuf_irq_flag
  import txbuf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_clr,
  input  logic tx_ie,
  input  logic mie,
  input  logic drain_evt,
  input  logic frame_end_evt,
  input  logic wr,
  input  logic clr_cmd,
  output logic set_evt,
  output logic ip,
  output logic irq
);

  logic ip_q;

  assign set_evt = tx_ie & ~wr & (drain_evt | frame_end_evt);
  assign ip      = ip_q;
  assign irq     = ip_q & tx_ie & mie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_q <= 1'b0;
    end else if (sync_clr) begin
      ip_q <= 1'b0;
    end else begin
      ip_q <= ip_next(ip_q, set_evt, wr | clr_cmd);
    end
  end

endmodule

// File: rtl/txbuf_irq_ctrl.sv
module txbuf_irq_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_hw_rst,
  input  logic              chan_rst,
  input  logic              sync_mode,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              tx_ie,
  input  logic              mie,
  input  logic              rst_txint_cmd,
  input  logic              sr_ready,
  output logic              sr_load,
  output logic [DATA_W-1:0] sr_data,
  input  logic              crc_first_load,
  input  logic              crc_end,
  output logic              buf_empty,
  output logic              tx_ip,
  output logic              tx_irq,
  output logic              crc_overrun
);

  // Internal events, named so the bound checker can see them.
  logic sync_clr;
  logic drain_evt;
  logic frame_end_evt;
  logic window_open;
  logic overrun_hit;
  logic ip_set_evt;

  assign sync_clr = soft_hw_rst | chan_rst;

  txbuf_hold #(.DATA_W(DATA_W)) hold_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_clr  (sync_clr),
    .wr        (cpu_wr),
    .wr_data   (cpu_data),
    .sr_ready  (sr_ready),
    .empty     (buf_empty),
    .data      (sr_data),
    .load_evt  (sr_load),
    .drain_evt (drain_evt)
  );

  txbuf_crc_guard guard_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sync_clr      (sync_clr),
    .sync_mode     (sync_mode),
    .first_load    (crc_first_load),
    .crc_end       (crc_end),
    .wr            (cpu_wr),
    .frame_end_evt (frame_end_evt),
    .window_open   (window_open),
    .overrun_hit   (overrun_hit),
    .overrun       (crc_overrun)
  );

  txbuf_irq_flag flag_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sync_clr      (sync_clr),
    .tx_ie         (tx_ie),
    .mie           (mie),
    .drain_evt     (drain_evt),
    .frame_end_evt (frame_end_evt),
    .wr            (cpu_wr),
    .clr_cmd       (rst_txint_cmd),
    .set_evt       (ip_set_evt),
    .ip            (tx_ip),
    .irq           (tx_irq)
  );

endmodule

// File: rtl/txbuf_irq_ctrl_checker.sv
module txbuf_irq_ctrl_checker (
  input logic clk,
  input logic rst_n,
  input logic soft_hw_rst,
  input logic chan_rst,
  input logic sync_mode,
  input logic cpu_wr,
  input logic tx_ie,
  input logic mie,
  input logic rst_txint_cmd,
  input logic sr_ready,
  input logic sr_load,
  input logic crc_end,
  input logic buf_empty,
  input logic tx_ip,
  input logic tx_irq,
  input logic crc_overrun,
  input logic window_open
);

  logic any_clr;
  assign any_clr = soft_hw_rst | chan_rst;

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    any_clr |=> (buf_empty && !tx_ip && !crc_overrun));

  assert_write_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !any_clr) |=> !buf_empty);

  assert_load_needs_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sr_load |-> (sr_ready && !buf_empty));

  assert_load_frees_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_load && !cpu_wr && !any_clr) |=> buf_empty);

  assert_ip_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ip) |-> $past(tx_ie && (sr_load || (crc_end && sync_mode))));

  assert_ip_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ie && !tx_ip) |=> !tx_ip);

  assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !any_clr) |=> !tx_ip);

  assert_cmd_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_txint_cmd && !sr_load && !crc_end) |=> !tx_ip);

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (tx_ip && tx_ie && mie));

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_overrun && !any_clr) |=> crc_overrun);

  assert_overrun_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_overrun) |-> $past(cpu_wr && window_open));

endmodule

bind txbuf_irq_ctrl txbuf_irq_ctrl_checker chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .soft_hw_rst   (soft_hw_rst),
  .chan_rst      (chan_rst),
  .sync_mode     (sync_mode),
  .cpu_wr        (cpu_wr),
  .tx_ie         (tx_ie),
  .mie           (mie),
  .rst_txint_cmd (rst_txint_cmd),
  .sr_ready      (sr_ready),
  .sr_load       (sr_load),
  .crc_end       (crc_end),
  .buf_empty     (buf_empty),
  .tx_ip         (tx_ip),
  .tx_irq        (tx_irq),
  .crc_overrun   (crc_overrun),
  .window_open   (window_open)
);

// File: tb/txbuf_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module txbuf_irq_ctrl_tb_top;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          soft_hw_rst = 1'b0;
  logic          chan_rst = 1'b0;
  logic          sync_mode = 1'b0;
  logic          cpu_wr = 1'b0;
  logic [DW-1:0] cpu_data = '0;
  logic          tx_ie = 1'b0;
  logic          mie = 1'b0;
  logic          rst_txint_cmd = 1'b0;
  logic          sr_ready = 1'b0;
  logic          sr_load;
  logic [DW-1:0] sr_data;
  logic          crc_first_load = 1'b0;
  logic          crc_end = 1'b0;
  logic          buf_empty;
  logic          tx_ip;
  logic          tx_irq;
  logic          crc_overrun;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  txbuf_irq_ctrl #(.DATA_W(DW)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .soft_hw_rst    (soft_hw_rst),
    .chan_rst       (chan_rst),
    .sync_mode      (sync_mode),
    .cpu_wr         (cpu_wr),
    .cpu_data       (cpu_data),
    .tx_ie          (tx_ie),
    .mie            (mie),
    .rst_txint_cmd  (rst_txint_cmd),
    .sr_ready       (sr_ready),
    .sr_load        (sr_load),
    .sr_data        (sr_data),
    .crc_first_load (crc_first_load),
    .crc_end        (crc_end),
    .buf_empty      (buf_empty),
    .tx_ip          (tx_ip),
    .tx_irq         (tx_irq),
    .crc_overrun    (crc_overrun)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One clock edge; pulses are dropped 1 ns after the edge, away from it.
  task automatic step();
    @(posedge clk);
    #1;
    cpu_wr = 1'b0; rst_txint_cmd = 1'b0; crc_first_load = 1'b0; crc_end = 1'b0;
    soft_hw_rst = 1'b0; chan_rst = 1'b0;
  endtask

  task automatic do_write(input logic [DW-1:0] d);
    cpu_wr = 1'b1; cpu_data = d;
    step();
  endtask

  task automatic do_load();
    sr_ready = 1'b1;
    step();
    sr_ready = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    chk("R1", "empty after reset", buf_empty, 1);
    chk("R1", "ip after reset", tx_ip, 0);
    chk("R1", "irq after reset", tx_irq, 0);
    chk("R1", "overrun after reset", crc_overrun, 0);
  endtask

  task automatic t_write_load();
    tx_ie = 1'b1; mie = 1'b1;
    do_write(8'hA5);
    chk("R2", "empty after write", buf_empty, 0);
    chk("R4", "ip after write only", tx_ip, 0);
    do_write(8'h3C);
    sr_ready = 1'b1; #1;
    chk("R3", "sr_load with byte held", sr_load, 1);
    chk("R2", "replaced byte", sr_data, 8'h3C);
    step(); sr_ready = 1'b0;
    chk("R3", "empty after load", buf_empty, 1);
    chk("R4", "ip after drain", tx_ip, 1);
    chk("R8", "irq with both enables", tx_irq, 1);
    sr_ready = 1'b1; #1;
    chk("R3", "no sr_load when free", sr_load, 0);
    sr_ready = 1'b0;
    do_write(8'h11);
    chk("R7", "ip cleared by write", tx_ip, 0);
    do_load();
    chk("R4", "ip after second drain", tx_ip, 1);
    rst_txint_cmd = 1'b1; step();
    chk("R7", "ip cleared by command", tx_ip, 0);
    chk("R7", "empty kept by command", buf_empty, 1);
    // Write and load in the same cycle: slot stays full, no drain.
    do_write(8'h22);
    cpu_wr = 1'b1; cpu_data = 8'h33; sr_ready = 1'b1; step(); sr_ready = 1'b0;
    chk("R3", "empty after load+write", buf_empty, 0);
    chk("R4", "ip after load+write", tx_ip, 0);
    do_load();
  endtask

  task automatic t_enable_while_empty();
    tx_ie = 1'b0;
    chan_rst = 1'b1; step();
    tx_ie = 1'b1;
    repeat (4) step();
    chk("R4", "ip after enabling on free slot", tx_ip, 0);
  endtask

  task automatic t_poll();
    tx_ie = 1'b0;
    do_write(8'h5A);
    chk("R5", "empty after write, ie off", buf_empty, 0);
    do_load();
    chk("R5", "empty after load, ie off", buf_empty, 1);
    chk("R5", "ip stays 0, ie off", tx_ip, 0);
  endtask

  task automatic t_mask();
    tx_ie = 1'b1; mie = 1'b1;
    do_write(8'h77); do_load();
    mie = 1'b0; #1;
    chk("R8", "irq masked by mie", tx_irq, 0);
    chk("R8", "ip kept under mask", tx_ip, 1);
    mie = 1'b1; #1;
    chk("R8", "irq back with mie", tx_irq, 1);
    tx_ie = 1'b0; #1;
    chk("R8", "irq masked by tx_ie", tx_irq, 0);
    chk("R8", "ip kept with tx_ie off", tx_ip, 1);
    tx_ie = 1'b1;
    rst_txint_cmd = 1'b1; step();
  endtask

  task automatic t_frame_end();
    tx_ie = 1'b1; mie = 1'b1; sync_mode = 1'b0;
    crc_end = 1'b1; step();
    chk("R6", "crc_end ignored async", tx_ip, 0);
    sync_mode = 1'b1;
    crc_end = 1'b1; step();
    chk("R6", "ip on frame end", tx_ip, 1);
    chk("R6", "empty on frame end", buf_empty, 1);
    rst_txint_cmd = 1'b1; step();
    chk("R7", "command clears", tx_ip, 0);
    crc_end = 1'b1; rst_txint_cmd = 1'b1; step();
    chk("R7", "set wins over command", tx_ip, 1);
    rst_txint_cmd = 1'b1; step();
  endtask

  task automatic t_overrun();
    sync_mode = 1'b1;
    crc_first_load = 1'b1; step();
    chk("R10", "no overrun without write", crc_overrun, 0);
    do_write(8'h99);
    chk("R9", "overrun on late write", crc_overrun, 1);
    crc_end = 1'b1; step();
    repeat (3) step();
    chk("R9", "overrun sticky", crc_overrun, 1);
    chan_rst = 1'b1; step();
    chk("R1", "chan reset clears overrun", crc_overrun, 0);
    crc_first_load = 1'b1; cpu_wr = 1'b1; cpu_data = 8'h01; step();
    chk("R9", "overrun on write in first-load cycle", crc_overrun, 1);
    crc_end = 1'b1; soft_hw_rst = 1'b1; step();
    chk("R1", "soft reset clears overrun", crc_overrun, 0);
    chk("R1", "soft reset frees slot", buf_empty, 1);
  endtask

  task automatic t_no_overrun();
    sync_mode = 1'b1;
    crc_first_load = 1'b1; step();
    crc_end = 1'b1; cpu_wr = 1'b1; cpu_data = 8'h02; step();
    chk("R10", "write in frame-end cycle", crc_overrun, 0);
    do_write(8'h03);
    chk("R10", "write after window", crc_overrun, 0);
    sync_mode = 1'b0;
    crc_first_load = 1'b1; step();
    do_write(8'h04);
    chk("R10", "first_load ignored async", crc_overrun, 0);
    chan_rst = 1'b1; step();
  endtask

  initial begin
    t_reset();
    t_write_load();
    t_enable_while_empty();
    t_poll();
    t_mask();
    t_frame_end();
    t_overrun();
    t_no_overrun();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule